// File: doc/BRIEF.md
# Stack Frame Shield Checker

This block sits on the data-memory request path between a processor core and its data cache. It holds three bounds that describe the live stack frame: a lower bound below which reads are forbidden, a lower bound below which writes are forbidden, and a frame-top bound above which memory holds stale data left behind by earlier calls. The control stack reloads all three bounds together through a side port on every call and return.

Each request is sorted into one of three outcomes in the cycle it arrives. An access under the relevant lower bound is stopped and reported on a trap port. An access inside the frame goes to the cache unchanged, with no added cycle. An access above the frame top is handled quietly. A read there never reaches the cache and returns a fixed canary word. A write there is performed, and the cache is told to drop every other word of that line and not to fetch the line first. This stops a callee from reading what an earlier callee left above the frame, and it costs no flush on return.

Top module: `stack_shield`

## Requirements
- R1: After reset the bounds are neutral: the read and write lower bounds are 0 and the frame top is all ones. No access traps or is hidden, and no read response or trap is signalled.
- R2: A read whose address is unsigned-less-than the read lower bound raises `trap_valid` in the same cycle, with `trap_addr` equal to the address and `trap_is_write` = 0. No cache request is issued and no read response follows.
- R3: A write whose address is unsigned-less-than the write lower bound raises `trap_valid` in the same cycle, with `trap_is_write` = 1 and `trap_addr` equal to the address. No cache request is issued.
- R4: A read or write inside the frame drives `cache_req_*` in the same cycle with the address, direction and write data unchanged. For a read, the cache data is returned on `core_rdata` with `core_rvalid` exactly `RD_LAT` cycles later, which is 1 by default.
- R5: A read whose address is unsigned-greater-than the frame top issues no cache request. `RD_LAT` cycles later it returns `core_rvalid` = 1 with `core_rdata` = `CANARY`.
- R6: A write whose address is unsigned-greater-than the frame top issues a cache write with `cache_inv_keep` = 1, meaning "write this word, invalidate the rest of the line, no line fill". `cache_keep_idx` is the word index inside the line, which is address bits [4:2] for a 32-byte line of 4-byte words. `cache_inv_keep` is 0 for every other access.
- R7: A bound load through `bnd_load` takes effect for accesses in the following cycle. An access in the same cycle as the load is judged against the old bounds.
- R8: The comparisons are unsigned and the edges are exact. An address equal to a lower bound passes. An address equal to the frame top passes. Any address above the top, up to 0xFFFFFFFC, is hidden.
- R9: When an access is both under its lower bound and above the frame top (inconsistent bounds), the trap wins: no cache request and no canary response.
- R10: The read and write lower bounds act independently. An address between them may be read, but writing to it traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bnd_load | input | 1 | Load all three bounds this cycle |
| bnd_rd_low | input | 32 | New read lower bound |
| bnd_wr_low | input | 32 | New write lower bound |
| bnd_top | input | 32 | New frame-top bound (highest address in the frame) |
| req_valid | input | 1 | Core access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| cache_req_valid | output | 1 | Request forwarded to the cache |
| cache_req_write | output | 1 | Forwarded direction |
| cache_req_addr | output | 32 | Forwarded address |
| cache_req_wdata | output | 32 | Forwarded write data |
| cache_inv_keep | output | 1 | Write the word, invalidate the rest of the line, no fill |
| cache_keep_idx | output | 3 | Word index kept valid in the line |
| cache_rvalid | input | 1 | Cache read data valid (fixed latency) |
| cache_rdata | input | 32 | Cache read data |
| core_rvalid | output | 1 | Read response to the core |
| core_rdata | output | 32 | Read data to the core |
| trap_valid | output | 1 | Access refused |
| trap_addr | output | 32 | Faulting address |
| trap_is_write | output | 1 | Faulting access was a write |

## Verification
The two functions that can meet in one cycle are a bound reload from the control stack and a core access. The bench provokes this by raising `bnd_load` in the same cycle as a read that lies between the old and new read lower bounds. It expects that read to pass, and expects the identical read one cycle later to trap. A second overlap, inconsistent bounds where trap and hiding both apply, is provoked by loading a read lower bound above the frame top. There the bench expects a trap with no canary response.

// File: rtl/shield_pkg.sv
// Shared types for the stack frame shield checker.
// Assumes byte addresses and a common address/data width.
package shield_pkg;
    localparam int SH_AW = 32;

    typedef enum logic [1:0] {
        ACC_PASS = 2'd0,
        ACC_TRAP = 2'd1,
        ACC_HIDE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic [SH_AW-1:0] rd_low;
        logic [SH_AW-1:0] wr_low;
        logic [SH_AW-1:0] top;
    } bounds_t;
endpackage

// File: rtl/shield_bounds.sv
// Bound register set. Holds the read lower bound, the write lower bound and
// the frame top. Assumes the control stack presents all three together with
// a load strobe; the new values are visible from the next cycle.
module shield_bounds
    import shield_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SH_AW-1:0] new_rd_low,
    input  logic [SH_AW-1:0] new_wr_low,
    input  logic [SH_AW-1:0] new_top,
    output bounds_t          bounds
);
    bounds_t bnd_q;

    // Capture new bounds on load; reset to a neutral frame covering all memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bnd_q.rd_low <= '0;
            bnd_q.wr_low <= '0;
            bnd_q.top    <= '1;
        end else if (load) begin
            bnd_q.rd_low <= new_rd_low;
            bnd_q.wr_low <= new_wr_low;
            bnd_q.top    <= new_top;
        end
    end

    assign bounds = bnd_q;
endmodule

// File: rtl/shield_classify.sv
// Combinational access classifier. Compares the request address, unsigned,
// against the bound set and picks trap, pass or hide. The trap has priority
// over hiding when the bounds are inconsistent. Assumes a valid request.
module shield_classify
    import shield_pkg::*;
(
    input  logic             is_write,
    input  logic [SH_AW-1:0] addr,
    input  bounds_t          bounds,
    output acc_kind_e        kind
);
    logic [SH_AW-1:0] low_sel;
    logic             under_low;
    logic             over_top;

    // Select the lower bound by direction and evaluate both comparisons.
    always_comb begin
        low_sel   = is_write ? bounds.wr_low : bounds.rd_low;
        under_low = addr < low_sel;
        over_top  = addr > bounds.top;
    end

    // Resolve the outcome, trap first.
    always_comb begin
        if (under_low)     kind = ACC_TRAP;
        else if (over_top) kind = ACC_HIDE;
        else               kind = ACC_PASS;
    end
endmodule

// File: rtl/shield_rdpath.sv
// Read response path. Tracks each accepted read for RD_LAT cycles, matching
// the cache's fixed read latency, and substitutes CANARY for hidden reads.
// Assumes the cache answers every forwarded read exactly RD_LAT cycles later.
module shield_rdpath #(
    parameter int          RD_LAT = 1,
    parameter int          DW     = 32,
    parameter logic [31:0] CANARY = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_accept,
    input  logic          rd_hide,
    input  logic          cache_rvalid,
    input  logic [DW-1:0] cache_rdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    logic [RD_LAT-1:0] vld_q;
    logic [RD_LAT-1:0] hid_q;

    for (genvar g = 0; g < RD_LAT; g++) begin : g_stage
        if (g == 0) begin : g_head
            // First stage takes the read accepted this cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[0] <= 1'b0;
                    hid_q[0] <= 1'b0;
                end else begin
                    vld_q[0] <= rd_accept;
                    hid_q[0] <= rd_accept & rd_hide;
                end
            end
        end else begin : g_body
            // Later stages shift the tracking bits forward.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[g] <= 1'b0;
                    hid_q[g] <= 1'b0;
                end else begin
                    vld_q[g] <= vld_q[g-1];
                    hid_q[g] <= hid_q[g-1];
                end
            end
        end
    end

    // Drive the response: canary for hidden reads, cache data otherwise.
    always_comb begin
        rsp_valid = vld_q[RD_LAT-1];
        if (!rsp_valid)                rsp_data = '0;
        else if (hid_q[RD_LAT-1])      rsp_data = CANARY[DW-1:0];
        else                           rsp_data = cache_rdata;
    end

    // R4
    pass_rd_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !hid_q[RD_LAT-1]) |-> cache_rvalid);
    // R5
    hidden_rd_no_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && hid_q[RD_LAT-1]) |-> !cache_rvalid);
    // R1
    no_rsp_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !rsp_valid);
endmodule

// File: rtl/stack_shield.sv
// Stack frame shield checker, top level. Sits between the core's data
// request port and the data cache. Traps accesses below the lower bounds,
// forwards in-frame accesses with no added cycle, returns a canary for reads
// above the frame top, and turns writes there into "write word, invalidate
// rest of line, no fill" commands. Assumes one request per cycle at most and
// a fixed-latency cache read.
module stack_shield
    import shield_pkg::*;
#(
    parameter int          LINE_BYTES = 32,
    parameter int          WORD_BYTES = 4,
    parameter int          RD_LAT     = 1,
    parameter logic [31:0] CANARY     = 32'h0,
    localparam int         OFF_W      = $clog2(WORD_BYTES),
    localparam int         IDX_W      = $clog2(LINE_BYTES / WORD_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd_load,
    input  logic [SH_AW-1:0] bnd_rd_low,
    input  logic [SH_AW-1:0] bnd_wr_low,
    input  logic [SH_AW-1:0] bnd_top,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [SH_AW-1:0] req_addr,
    input  logic [SH_AW-1:0] req_wdata,
    output logic             cache_req_valid,
    output logic             cache_req_write,
    output logic [SH_AW-1:0] cache_req_addr,
    output logic [SH_AW-1:0] cache_req_wdata,
    output logic             cache_inv_keep,
    output logic [IDX_W-1:0] cache_keep_idx,
    input  logic             cache_rvalid,
    input  logic [SH_AW-1:0] cache_rdata,
    output logic             core_rvalid,
    output logic [SH_AW-1:0] core_rdata,
    output logic             trap_valid,
    output logic [SH_AW-1:0] trap_addr,
    output logic             trap_is_write
);
    bounds_t   bounds;
    acc_kind_e kind;

    shield_bounds u_bounds (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (bnd_load),
        .new_rd_low (bnd_rd_low),
        .new_wr_low (bnd_wr_low),
        .new_top    (bnd_top),
        .bounds     (bounds)
    );

    shield_classify u_classify (
        .is_write (req_write),
        .addr     (req_addr),
        .bounds   (bounds),
        .kind     (kind)
    );

    // Steer the request to the cache or the trap port by outcome.
    always_comb begin
        trap_valid      = req_valid && (kind == ACC_TRAP);
        trap_addr       = trap_valid ? req_addr : '0;
        trap_is_write   = trap_valid && req_write;
        cache_req_valid = req_valid && ((kind == ACC_PASS) ||
                                        (kind == ACC_HIDE && req_write));
        cache_req_write = cache_req_valid && req_write;
        cache_req_addr  = cache_req_valid ? req_addr : '0;
        cache_req_wdata = cache_req_write ? req_wdata : '0;
        cache_inv_keep  = cache_req_write && (kind == ACC_HIDE);
        cache_keep_idx  = cache_inv_keep ? req_addr[OFF_W +: IDX_W] : '0;
    end

    logic rd_accept;
    logic rd_hide;

    // A read that is not trapped produces a response, real or canary.
    always_comb begin
        rd_accept = req_valid && !req_write && (kind != ACC_TRAP);
        rd_hide   = (kind == ACC_HIDE);
    end

    shield_rdpath #(
        .RD_LAT (RD_LAT),
        .DW     (SH_AW),
        .CANARY (CANARY)
    ) u_rdpath (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_accept    (rd_accept),
        .rd_hide      (rd_hide),
        .cache_rvalid (cache_rvalid),
        .cache_rdata  (cache_rdata),
        .rsp_valid    (core_rvalid),
        .rsp_data     (core_rdata)
    );

    // R2 R3
    trap_blocks_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> !cache_req_valid);
    // R6
    inv_keep_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_inv_keep |-> (cache_req_valid && cache_req_write && req_valid));
    // R9
    trap_over_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> !cache_inv_keep);
    // R7
    new_bound_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bnd_load) && req_valid && !req_write &&
         (req_addr < $past(bnd_rd_low))) |-> trap_valid);
    // R4
    pass_unchanged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_req_valid && !cache_inv_keep) |->
            (cache_req_addr == req_addr && cache_req_write == req_write));
endmodule

// File: tb/tb_stack_shield.sv
module tb_stack_shield;
    localparam logic [31:0] CAN = 32'hC0DE_F00D;
    localparam logic [31:0] SCR = 32'hA5A5_5A5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bnd_load = 1'b0;
    logic [31:0] bnd_rd_low = '0, bnd_wr_low = '0, bnd_top = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        cache_req_valid, cache_req_write, cache_inv_keep;
    logic [31:0] cache_req_addr, cache_req_wdata;
    logic [2:0]  cache_keep_idx;
    logic        cache_rvalid;
    logic [31:0] cache_rdata;
    logic        core_rvalid, trap_valid, trap_is_write;
    logic [31:0] core_rdata, trap_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stack_shield #(.CANARY(CAN)) dut (
        .clk(clk), .rst_n(rst_n), .bnd_load(bnd_load),
        .bnd_rd_low(bnd_rd_low), .bnd_wr_low(bnd_wr_low), .bnd_top(bnd_top),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .cache_req_valid(cache_req_valid),
        .cache_req_write(cache_req_write), .cache_req_addr(cache_req_addr),
        .cache_req_wdata(cache_req_wdata), .cache_inv_keep(cache_inv_keep),
        .cache_keep_idx(cache_keep_idx), .cache_rvalid(cache_rvalid),
        .cache_rdata(cache_rdata), .core_rvalid(core_rvalid),
        .core_rdata(core_rdata), .trap_valid(trap_valid),
        .trap_addr(trap_addr), .trap_is_write(trap_is_write)
    );

    // Cache model: one-cycle read latency, data derived from the address.
    always_ff @(posedge clk) begin
        cache_rvalid <= cache_req_valid && !cache_req_write;
        cache_rdata  <= cache_req_addr ^ SCR;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Kind codes: 0 pass, 1 trap, 2 hide.
    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [1:0]  kind;
    } vec_t;

    // Bounds for the table: rd_low 0x1000, wr_low 0x2000, top 0x8000.
    localparam vec_t VECS [13] = '{
        '{1'b0, 32'h0000_0FFC, 2'd1},  // R2 read under bound
        '{1'b0, 32'h0000_1000, 2'd0},  // R8 read at bound
        '{1'b0, 32'h0000_1800, 2'd0},  // R10 read between bounds
        '{1'b1, 32'h0000_1800, 2'd1},  // R10 write between bounds
        '{1'b1, 32'h0000_1FFC, 2'd1},  // R3 write under bound
        '{1'b1, 32'h0000_2000, 2'd0},  // R8 write at bound
        '{1'b0, 32'h0000_4000, 2'd0},  // R4 in-frame read
        '{1'b1, 32'h0000_4004, 2'd0},  // R4 in-frame write
        '{1'b0, 32'h0000_8000, 2'd0},  // R8 read at top
        '{1'b0, 32'h0000_8004, 2'd2},  // R5 hidden read
        '{1'b1, 32'h0000_8014, 2'd2},  // R6 hidden write, idx 5
        '{1'b0, 32'hFFFF_FFFC, 2'd2},  // R8 unsigned high
        '{1'b1, 32'h0000_0004, 2'd1}   // R3 unsigned low
    };

    task automatic load_bounds(input logic [31:0] rl, input logic [31:0] wl, input logic [31:0] tp);
        @(negedge clk);
        bnd_load = 1'b1; bnd_rd_low = rl; bnd_wr_low = wl; bnd_top = tp;
        @(negedge clk);
        bnd_load = 1'b0;
    endtask

    initial begin
        #(200_000 * 10);
        errors++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 trap idle", {31'b0, trap_valid}, 32'h0);
        chk("R1 rvalid idle", {31'b0, core_rvalid}, 32'h0);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'hFFFF_FFFC; #1;
        chk("R1 high read passes", {31'b0, cache_req_valid}, 32'h1);
        req_addr = 32'h0; #1;
        chk("R1 zero read no trap", {31'b0, trap_valid}, 32'h0);
        @(negedge clk); req_valid = 1'b0;

        load_bounds(32'h1000, 32'h2000, 32'h8000);

        foreach (VECS[i]) begin
            vec_t v;
            logic [31:0] wd;
            v = VECS[i];
            wd = 32'h1111_0000 + i;
            @(negedge clk);
            req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_wdata = wd;
            #1;
            chk($sformatf("vec%0d trap", i), {31'b0, trap_valid}, {31'b0, v.kind == 2'd1});
            chk($sformatf("vec%0d cache_req", i), {31'b0, cache_req_valid},
                {31'b0, (v.kind == 2'd0) || (v.kind == 2'd2 && v.wr)});
            chk($sformatf("vec%0d inv_keep", i), {31'b0, cache_inv_keep},
                {31'b0, v.kind == 2'd2 && v.wr});
            if (v.kind == 2'd1) begin
                chk($sformatf("vec%0d trap_addr", i), trap_addr, v.addr);
                chk($sformatf("vec%0d trap_wr", i), {31'b0, trap_is_write}, {31'b0, v.wr});
            end else if (v.wr || v.kind == 2'd0) begin
                chk($sformatf("vec%0d fwd addr", i), cache_req_addr, v.addr);
                if (v.wr) chk($sformatf("vec%0d fwd wdata", i), cache_req_wdata, wd);
            end
            if (v.kind == 2'd2 && v.wr)
                chk($sformatf("vec%0d keep_idx", i), {29'b0, cache_keep_idx}, {29'b0, v.addr[4:2]});
            @(negedge clk);
            req_valid = 1'b0;
            chk($sformatf("vec%0d rvalid", i), {31'b0, core_rvalid},
                {31'b0, !v.wr && v.kind != 2'd1});
            if (!v.wr && v.kind != 2'd1)
                chk($sformatf("vec%0d rdata", i), core_rdata,
                    (v.kind == 2'd2) ? CAN : (v.addr ^ SCR));
        end

        // R7 load and access collide: old bounds apply this cycle.
        @(negedge clk);
        bnd_load = 1'b1; bnd_rd_low = 32'h3000; bnd_wr_low = 32'h3000; bnd_top = 32'h8000;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h2000; #1;
        chk("R7 same cycle old bound", {31'b0, trap_valid}, 32'h0);
        @(negedge clk);
        bnd_load = 1'b0; #1;
        chk("R7 next cycle new bound", {31'b0, trap_valid}, 32'h1);
        chk("R7 trap addr", trap_addr, 32'h2000);
        @(negedge clk); req_valid = 1'b0;

        // R9 inconsistent bounds: trap beats hide.
        load_bounds(32'h9000, 32'h9000, 32'h8000);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h8800; #1;
        chk("R9 read trap", {31'b0, trap_valid}, 32'h1);
        chk("R9 read no cache", {31'b0, cache_req_valid}, 32'h0);
        @(negedge clk);
        req_write = 1'b1; #1;
        chk("R9 write no inv", {31'b0, cache_inv_keep}, 32'h0);
        chk("R9 no canary rsp", {31'b0, core_rvalid}, 32'h0);
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        chk("R9 still no rsp", {31'b0, core_rvalid}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule